// File: doc/BRIEF.md
# I2C Controller FIFO and Interrupt Front-End

This block sits between a CPU-side register port and a serial bus engine. It queues outgoing command words in a transmit FIFO. It collects incoming data bytes in a receive FIFO. It turns engine events and FIFO conditions into one interrupt line. Software pushes commands by writing a command register and drains received bytes by reading a data register. The engine pops commands and pushes received bytes through its own ports.

Each FIFO has a clear control that software holds high and then drops before a transfer. Each FIFO also has a programmable threshold. When the receive level reaches its threshold, or the transmit level falls to its threshold, an interrupt source is raised. Misuse is latched per direction and per kind: a pop from an empty FIFO or a push into a full one. All misuse collapses into a single FIFO-error interrupt source. Five sources feed a pending latch. Software reads that latch raw or masked and clears it by writing ones.

Top module: `fifo_irq_front`

## Requirements
- R1: After reset both FIFOs are empty, the mask is 0, the masked status reads 0 and `irq` is low. The state register reads 0x8. Raw status reads 0x18, because both threshold conditions hold at level 0 with thresholds 0.
- R2: The transmit FIFO holds DEPTH (64) command words.
  - Words written to offset 0 (bits CMD_W-1:0) leave on `eng_tx_data` in write order.
  - State bit 11 (TX full) is set at 64 entries.
  - State bits 30:24 hold the TX level.
- R3: The receive FIFO holds 64 bytes. Reads of offset 1 return them in push order and pop one each. State bit 3 (RX empty) is set at level 0. State bits 22:16 hold the RX level.
- R4: A write to offset 0 while the TX FIFO is full leaves the FIFO unchanged and sets state bit 7 (TX write error). An engine push while the RX FIFO is full is likewise dropped and sets state bit 1 (RX write error).
- R5: An engine pop of an empty TX FIFO sets state bit 6 (TX read error). A read of offset 1 while the RX FIFO is empty returns 0 and sets state bit 0 (RX read error).
- R6: Control register at offset 2: bit 0 clears RX and bit 1 clears TX.
  - While a clear bit is 1, that FIFO is held empty and its two error bits read 0.
  - Pushes into that FIFO are ignored while its clear bit is 1.
- R7: Control bits 7:2 set the RX threshold. Interrupt bit 3 becomes pending one cycle after the RX level is at or above it.
- R8: Control bits 13:8 set the TX threshold. Interrupt bit 4 becomes pending one cycle after the TX level is at or below it.
- R9: Any FIFO misuse sets interrupt bit 2 (FIFO error).
- R10: A pulse on `ev_done` sets interrupt bit 0. A pulse on `ev_xfer_err` sets interrupt bit 1.
- R11: The mask register at offset 6 enables a source when its bit is 1. Masked status at offset 4 returns pending AND mask. `irq` is the OR of the masked bits. Raw pending reads at offset 7.
- R12: Writing ones to offset 5 clears those pending bits. A source that is still true in the same cycle wins, so a threshold condition re-latches while it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at offset 1) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| eng_tx_data | output | CMD_W | Head of the transmit FIFO |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_tx_pop | input | 1 | Engine pops one command |
| eng_rx_push | input | 1 | Engine pushes one byte |
| eng_rx_data | input | RXD_W | Byte pushed by the engine |
| eng_rx_ready | output | 1 | Receive FIFO not full |
| ev_done | input | 1 | Transfer-complete event pulse |
| ev_xfer_err | input | 1 | Transfer-error event pulse |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted FIFO pointer or count appears at once in the level fields of the state register. It then appears in the order of words leaving `eng_tx_data` or read from offset 1, within the length of one full fill-and-drain. A wrong threshold comparison or a lost set-over-clear priority shows at raw status one cycle after the level changes. A masking fault shows on `irq` in the same cycle the mask is written. The bench therefore sweeps fills to full and beyond, drains past empty, and walks each threshold across several values with the level just below and just at the trip point.

// File: rtl/fifo_irq_pkg.sv
// Package: register offsets and interrupt bit positions shared by the
// front-end, its sub-blocks, the checker and the bench.
package fifo_irq_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RXD   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATE = 3'd3;
    localparam logic [ADDR_W-1:0] A_MSTAT = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR   = 3'd5;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd6;
    localparam logic [ADDR_W-1:0] A_RAW   = 3'd7;

    localparam int N_IRQ    = 5;
    localparam int IRQ_DONE = 0;
    localparam int IRQ_XERR = 1;
    localparam int IRQ_FERR = 2;
    localparam int IRQ_RXTH = 3;
    localparam int IRQ_TXTH = 4;
endpackage

// File: rtl/sync_fifo.sv
// Module: sync_fifo
// Single-clock FIFO with a synchronous hold-clear. Misuse (push when full,
// pop when empty) leaves the contents unchanged and is reported as a
// one-cycle pulse. Assumes clr has priority over push and pop.
module sync_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty,
    output logic                         push_err,
    output logic                         pop_err
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             push_ok, pop_ok;

    assign full     = (count == LVL_W'(DEPTH));
    assign empty    = (count == '0);
    assign push_ok  = push & ~full & ~clr;
    assign pop_ok   = pop & ~empty & ~clr;
    assign push_err = push & full & ~clr;
    assign pop_err  = pop & empty & ~clr;
    assign level    = count;
    assign head     = empty ? '0 : mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/irq_aggr.sv
// Module: irq_aggr
// Pending latch for N interrupt sources with write-one-to-clear. A source
// asserted in the same cycle as its clear stays pending. The output is the
// OR of pending bits enabled by the mask.
module irq_aggr #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] masked_o,
    output logic         irq_o
);
    // Latch sources, drop cleared bits, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end

    assign masked_o = pend_o & mask_i;
    assign irq_o    = |masked_o;
endmodule

// File: rtl/fifo_irq_front.sv
// Module: fifo_irq_front
// Register-side front-end: command FIFO toward the engine, data FIFO from
// it, per-direction misuse latches, threshold events and the interrupt
// aggregator. Assumes THR_W threshold fields fit bits 13:2 of control and
// level fields fit 8 bits in the state register.
module fifo_irq_front
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CMD_W = 11,
    parameter int RXD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [CMD_W-1:0]  eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [RXD_W-1:0]  eng_rx_data,
    output logic              eng_rx_ready,
    input  logic              ev_done,
    input  logic              ev_xfer_err,
    output logic              irq
);
    localparam int LVL_W   = $clog2(DEPTH + 1);
    localparam int THR_W   = $clog2(DEPTH);
    localparam int RXT_LSB = 2;
    localparam int TXT_LSB = 2 + THR_W;

    logic             rx_clr, tx_clr;
    logic [THR_W-1:0] rx_thr, tx_thr;
    logic [N_IRQ-1:0] mask, pend, masked, irq_set, irq_clr;
    logic             cmd_push, rxd_pop;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_push_err, tx_pop_err, rx_push_err, rx_pop_err;
    logic [RXD_W-1:0] rx_head;
    logic             rx_rerr, rx_werr, tx_rerr, tx_werr;

    assign cmd_push = reg_wr && (reg_addr == A_CMD);
    assign rxd_pop  = reg_rd && (reg_addr == A_RXD);

    // Control and mask registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_clr <= 1'b0;
            tx_clr <= 1'b0;
            rx_thr <= '0;
            tx_thr <= '0;
            mask   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                rx_clr <= reg_wdata[0];
                tx_clr <= reg_wdata[1];
                rx_thr <= reg_wdata[RXT_LSB +: THR_W];
                tx_thr <= reg_wdata[TXT_LSB +: THR_W];
            end
            if (reg_addr == A_MASK) mask <= reg_wdata[N_IRQ-1:0];
        end
    end

    sync_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(cmd_push), .push_data(reg_wdata[CMD_W-1:0]),
        .pop(eng_tx_pop), .head(eng_tx_data), .level(tx_level),
        .full(tx_full), .empty(tx_empty),
        .push_err(tx_push_err), .pop_err(tx_pop_err)
    );

    sync_fifo #(.DEPTH(DEPTH), .W(RXD_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rxd_pop), .head(rx_head), .level(rx_level),
        .full(rx_full), .empty(rx_empty),
        .push_err(rx_push_err), .pop_err(rx_pop_err)
    );

    assign eng_tx_valid = ~tx_empty;
    assign eng_rx_ready = ~rx_full;

    // Misuse latches per direction, dropped by that direction's clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rerr <= 1'b0; rx_werr <= 1'b0;
            tx_rerr <= 1'b0; tx_werr <= 1'b0;
        end else begin
            if (rx_clr) begin
                rx_rerr <= 1'b0; rx_werr <= 1'b0;
            end else begin
                rx_rerr <= rx_rerr | rx_pop_err;
                rx_werr <= rx_werr | rx_push_err;
            end
            if (tx_clr) begin
                tx_rerr <= 1'b0; tx_werr <= 1'b0;
            end else begin
                tx_rerr <= tx_rerr | tx_pop_err;
                tx_werr <= tx_werr | tx_push_err;
            end
        end
    end

    // Interrupt source vector and write-one-to-clear vector.
    always_comb begin
        irq_set           = '0;
        irq_set[IRQ_DONE] = ev_done;
        irq_set[IRQ_XERR] = ev_xfer_err;
        irq_set[IRQ_FERR] = tx_push_err | tx_pop_err | rx_push_err | rx_pop_err;
        irq_set[IRQ_RXTH] = (rx_level >= LVL_W'(rx_thr));
        irq_set[IRQ_TXTH] = (tx_level <= LVL_W'(tx_thr));
        irq_clr = (reg_wr && reg_addr == A_CLR) ? reg_wdata[N_IRQ-1:0] : '0;
    end

    irq_aggr #(.N(N_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr),
        .mask_i(mask), .pend_o(pend), .masked_o(masked), .irq_o(irq)
    );

    // Read multiplexer over all register offsets.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RXD:   reg_rdata[RXD_W-1:0] = rx_head;
            A_CTRL: begin
                reg_rdata[0] = rx_clr;
                reg_rdata[1] = tx_clr;
                reg_rdata[RXT_LSB +: THR_W] = rx_thr;
                reg_rdata[TXT_LSB +: THR_W] = tx_thr;
            end
            A_STATE: begin
                reg_rdata[0]  = rx_rerr;
                reg_rdata[1]  = rx_werr;
                reg_rdata[3]  = rx_empty;
                reg_rdata[6]  = tx_rerr;
                reg_rdata[7]  = tx_werr;
                reg_rdata[11] = tx_full;
                reg_rdata[16 +: LVL_W] = rx_level;
                reg_rdata[24 +: LVL_W] = tx_level;
            end
            A_MSTAT: reg_rdata[N_IRQ-1:0] = masked;
            A_MASK:  reg_rdata[N_IRQ-1:0] = mask;
            A_RAW:   reg_rdata[N_IRQ-1:0] = pend;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fifo_irq_front_chk.sv
// Module: fifo_irq_front_chk
// Property checker bound into fifo_irq_front; observes FIFO levels,
// pending bits and the interrupt line.
module fifo_irq_front_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] tx_level,
    input logic             tx_full,
    input logic             cmd_push,
    input logic             eng_tx_pop,
    input logic             tx_clr,
    input logic             tx_push_err,
    input logic             ev_done,
    input logic [4:0]       pend,
    input logic [4:0]       mask,
    input logic             irq
);
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(DEPTH));

    p_full_no_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && cmd_push && !eng_tx_pop && !tx_clr) |=> $stable(tx_level));

    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> (tx_level == '0));

    p_ferr_pends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_err |=> pend[2]);

    p_done_pends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> pend[0]);

    p_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 5'd0) |-> !irq);
endmodule

bind fifo_irq_front fifo_irq_front_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_full(tx_full),
    .cmd_push(cmd_push), .eng_tx_pop(eng_tx_pop), .tx_clr(tx_clr),
    .tx_push_err(tx_push_err), .ev_done(ev_done), .pend(pend),
    .mask(mask), .irq(irq)
);

// File: tb/test_fifo_irq_front.sv
// Bench: fills, drains and threshold sweeps with arithmetic expectations.
module test_fifo_irq_front;
    import fifo_irq_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] eng_tx_data;
    logic        eng_tx_valid, eng_rx_ready, irq;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        ev_done = 1'b0, ev_xfer_err = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_irq_front i_fifo_irq_front (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
        .ev_done(ev_done), .ev_xfer_err(ev_xfer_err), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic eng_push(input logic [7:0] d);
        @(negedge clk); eng_rx_data = d; eng_rx_push = 1'b1;
        @(negedge clk); eng_rx_push = 1'b0;
    endtask

    task automatic eng_pop(output logic [10:0] d);
        @(negedge clk); #1 d = eng_tx_data; eng_tx_pop = 1'b1;
        @(negedge clk); eng_tx_pop = 1'b0;
    endtask

    function automatic logic [10:0] tx_pat(input int i);
        return 11'((i * 37 + 5) % 2048);
    endfunction

    function automatic logic [7:0] rx_pat(input int i);
        return 8'((i * 13 + 7) % 256);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [10:0] t;
        int tx_thr_list [4] = '{0, 2, 9, 62};
        int rx_thr_list [5] = '{1, 7, 33, 60, 63};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STATE, v); check("R1 state", v, 32'h8);
        rd(A_MSTAT, v); check("R1 masked", v, 32'h0);
        rd(A_RAW, v);   check("R1 raw", v, 32'h18);
        check("R1 irq", {31'd0, irq}, 32'h0);

        wr(A_CTRL, (60 << 2) | (1 << 8));

        // R2 fill TX to full
        for (int i = 0; i < DEPTH; i++) wr(A_CMD, {21'd0, tx_pat(i)});
        rd(A_STATE, v); check("R2 tx full", v, 32'h40000808);
        // R4 write when full is dropped
        wr(A_CMD, 32'h7FF);
        rd(A_STATE, v); check("R4 tx werr", v, 32'h40000888);
        rd(A_RAW, v);   check("R9 ferr pend", v & 32'h4, 32'h4);
        begin
            int bad = 0;
            for (int i = 0; i < DEPTH; i++) begin
                eng_pop(t);
                if (t !== tx_pat(i)) begin
                    bad++;
                    $display("FAIL R2 order idx %0d actual=0x%03h expected=0x%03h", i, t, tx_pat(i));
                end
            end
            checks++;
            if (bad != 0) fails++;
        end
        // R5 pop of empty TX
        eng_pop(t);
        rd(A_STATE, v); check("R5 tx rerr", v, 32'h000000C8);
        // R6 clear held: errors gone, pushes ignored
        wr(A_CTRL, (60 << 2) | (1 << 8) | 2);
        wr(A_CMD, 32'h123);
        rd(A_STATE, v); check("R6 tx clear held", v, 32'h8);
        wr(A_CTRL, (60 << 2) | (1 << 8));

        // R3 fill RX to full
        for (int i = 0; i < DEPTH; i++) eng_push(rx_pat(i));
        rd(A_STATE, v); check("R3 rx level", v, 32'h00400000);
        eng_push(8'hEE);
        rd(A_STATE, v); check("R4 rx werr", v, 32'h00400002);
        begin
            int bad = 0;
            for (int i = 0; i < DEPTH; i++) begin
                rd(A_RXD, v);
                if (v !== {24'd0, rx_pat(i)}) begin
                    bad++;
                    $display("FAIL R3 order idx %0d actual=0x%02h expected=0x%02h", i, v, rx_pat(i));
                end
            end
            checks++;
            if (bad != 0) fails++;
        end
        rd(A_RXD, v);   check("R5 rx empty read", v, 32'h0);
        rd(A_STATE, v); check("R5 rx rerr", v, 32'h0000000B);
        wr(A_CTRL, (60 << 2) | (1 << 8) | 1);
        rd(A_STATE, v); check("R6 rx clear held", v, 32'h8);

        // R7 / R12 RX threshold sweep
        foreach (rx_thr_list[k]) begin
            int th = rx_thr_list[k];
            wr(A_CTRL, (th << 2) | (1 << 8) | 1);
            wr(A_CTRL, (th << 2) | (1 << 8));
            for (int i = 0; i < th - 1; i++) eng_push(rx_pat(i));
            idle(2);
            wr(A_CLR, 32'h8); idle(2);
            rd(A_RAW, v); check($sformatf("R7 below thr %0d", th), v & 32'h8, 32'h0);
            eng_push(8'h55); idle(2);
            rd(A_RAW, v); check($sformatf("R7 at thr %0d", th), v & 32'h8, 32'h8);
            wr(A_CLR, 32'h8); idle(1);
            rd(A_RAW, v); check($sformatf("R12 relatch thr %0d", th), v & 32'h8, 32'h8);
        end

        // R8 TX threshold sweep
        foreach (tx_thr_list[k]) begin
            int th = tx_thr_list[k];
            wr(A_CTRL, (60 << 2) | (th << 8) | 2);
            wr(A_CTRL, (60 << 2) | (th << 8));
            for (int i = 0; i <= th; i++) wr(A_CMD, {21'd0, tx_pat(i)});
            idle(2);
            wr(A_CLR, 32'h10); idle(2);
            rd(A_RAW, v); check($sformatf("R8 above thr %0d", th), v & 32'h10, 32'h0);
            eng_pop(t); idle(2);
            rd(A_RAW, v); check($sformatf("R8 at thr %0d", th), v & 32'h10, 32'h10);
        end

        // R10 engine events
        wr(A_CLR, 32'h3); idle(1);
        rd(A_RAW, v); check("R12 w1c events", v & 32'h3, 32'h0);
        @(negedge clk); ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        rd(A_RAW, v); check("R10 done", v & 32'h3, 32'h1);
        @(negedge clk); ev_xfer_err = 1'b1; @(negedge clk); ev_xfer_err = 1'b0;
        rd(A_RAW, v); check("R10 xfer err", v & 32'h3, 32'h3);

        // R11 masking
        wr(A_MASK, 32'h1);
        rd(A_MSTAT, v); check("R11 masked done", v, 32'h1);
        check("R11 irq on", {31'd0, irq}, 32'h1);
        wr(A_CLR, 32'h1);
        rd(A_MSTAT, v); check("R11 masked after clear", v, 32'h0);
        check("R11 irq off", {31'd0, irq}, 32'h0);
        wr(A_MASK, 32'h2);
        check("R11 irq err", {31'd0, irq}, 32'h1);
        wr(A_MASK, 32'h0);
        check("R11 irq masked", {31'd0, irq}, 32'h0);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule